// File: doc/BRIEF.md
# Home-Node Presence-Vector Directory Controller

This block sits at the home node of a distributed shared-memory machine and keeps one directory entry per memory line it owns. Each entry holds a line state and a presence vector with one bit per cluster. The controller takes coherence requests from remote clusters and updates the matching entry. It answers with a single outbound message. That message can be a data reply, an exclusive grant, a retry refusal, a fetch to the current owner, or one multicast invalidate.

Invalidation is sent as one message that carries a destination mask. The network does the fan-out. The controller loads a per-line counter with the number of clusters it invalidated. It grants write ownership only after that many acknowledgements have come back. While a line waits for acknowledgements or for an owner's writeback, it is locked: new reads and writes to that line are refused so the requester retries. Other lines keep running normally.

Top module: `dir_home_ctrl`

## Requirements
- R1: Request kinds are encoded on `req_kind` as 0 = read, 1 = write, 2 = writeback, 3 = invalidate-ack. Message kinds on `msg_kind` are 1 = data, 2 = grant, 3 = nack, 4 = fetch, 5 = invalidate. Each accepted request produces at most one message, on the clock edge that follows the request cycle. Every message except invalidate names exactly one cluster in `msg_dst`, where bit i stands for cluster i.
- R2: A read to an uncached or shared line returns data to the requester and records it as a holder. A read from the current exclusive owner returns data and leaves the line exclusive.
- R3: A read to a line held exclusive by another cluster sends a fetch to the owner. When the owner's writeback arrives, data goes to the reader, and both the owner and the reader are left as shared holders.
- R4: A write to a line with no other holders is granted at once. Otherwise a single invalidate goes out whose mask is every holder except the requester.
- R5: A write that needed invalidation is granted only on the acknowledgement that brings the count of outstanding acks to zero. Earlier acks produce no message.
- R6: A read or write to a line that is waiting for acks or for a writeback gets a nack to the requester. Requests to other lines are served normally.
- R7: A writeback from the exclusive owner leaves the line uncached and sends no message. A writeback from a cluster that is not the owner is ignored.
- R8: An acknowledgement for a line that is not waiting for acks is ignored.
- R9: An exclusive line has exactly one holder, so there is never more than one writer.
- R10: After reset every line is uncached and no message is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Request kind (R1 encoding) |
| req_src | input | $clog2(NCLUST) | Requesting cluster |
| req_line | input | $clog2(NLINES) | Directory line index |
| msg_valid | output | 1 | Outbound message present |
| msg_kind | output | 3 | Message kind (R1 encoding) |
| msg_dst | output | NCLUST | Destination mask, one bit per cluster |
| msg_line | output | $clog2(NLINES) | Line the message concerns |

## Verification
The bench targets the following corner cases:
- Invalidate masks that must leave out the requester. A design that included the requester would make that cluster invalidate its own copy.
- Multi-ack writes where the grant must wait for the last ack. A premature grant would create two writers at once.
- The fetch-then-writeback path, which must leave both clusters as sharers. Losing a bit would skip a later invalidation.
- The retry lock, which must affect only the busy line.
- Writebacks from non-owners and stray acks, which must leave state untouched. A design that honoured them would drop ownership or fire a spurious grant.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NCLUST = 16,
  parameter int NLINES = 4,
  localparam int SW = $clog2(NCLUST),
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [SW-1:0]     req_src,
  input  logic [LW-1:0]     req_line,
  output logic              msg_valid,
  output logic [2:0]        msg_kind,
  output logic [NCLUST-1:0] msg_dst,
  output logic [LW-1:0]     msg_line
);
  localparam logic [1:0] RQ_RD = 2'd0, RQ_WR = 2'd1, RQ_WB = 2'd2, RQ_ACK = 2'd3;
  localparam logic [2:0] M_DATA = 3'd1, M_GRANT = 3'd2, M_NACK = 3'd3,
                         M_FETCH = 3'd4, M_INVAL = 3'd5;

  typedef enum logic [2:0] {L_UNC, L_SHR, L_EXC, L_WACK, L_WWB} lst_t;

  lst_t              st   [NLINES];
  logic [NCLUST-1:0] pres [NLINES];
  logic [SW-1:0]     pend [NLINES];
  logic [SW:0]       cnt  [NLINES];

  lst_t              cur_st, nx_st;
  logic [NCLUST-1:0] cur_pres, nx_pres, src_bit, pend_bit, others;
  logic [SW-1:0]     nx_pend;
  logic [SW:0]       cur_cnt, nx_cnt;
  logic              own, busy, o_v;
  logic [2:0]        o_k;
  logic [NCLUST-1:0] o_d;

  assign cur_st   = st[req_line];
  assign cur_pres = pres[req_line];
  assign cur_cnt  = cnt[req_line];
  assign src_bit  = NCLUST'(1) << req_src;
  assign pend_bit = NCLUST'(1) << pend[req_line];
  assign others   = cur_pres & ~src_bit;
  assign own      = (cur_pres & src_bit) != '0;
  assign busy     = (cur_st == L_WACK) || (cur_st == L_WWB);

  always_comb begin
    nx_st   = cur_st;
    nx_pres = cur_pres;
    nx_pend = pend[req_line];
    nx_cnt  = cur_cnt;
    o_v     = 1'b0;
    o_k     = 3'd0;
    o_d     = '0;
    case (req_kind)
      RQ_RD: begin
        o_v = 1'b1;
        if (busy) begin
          o_k = M_NACK; o_d = src_bit;
        end else if (cur_st == L_EXC && !own) begin
          o_k = M_FETCH; o_d = cur_pres;
          nx_st = L_WWB; nx_pend = req_src;
        end else if (cur_st == L_EXC) begin
          o_k = M_DATA; o_d = src_bit;
        end else begin
          o_k = M_DATA; o_d = src_bit;
          nx_st = L_SHR; nx_pres = cur_pres | src_bit;
        end
      end
      RQ_WR: begin
        o_v = 1'b1;
        if (busy) begin
          o_k = M_NACK; o_d = src_bit;
        end else if (others == '0) begin
          o_k = M_GRANT; o_d = src_bit;
          nx_st = L_EXC; nx_pres = src_bit;
        end else begin
          o_k = M_INVAL; o_d = others;
          nx_st = L_WACK; nx_pend = req_src;
          nx_cnt = (SW+1)'($countones(others));
        end
      end
      RQ_WB: begin
        if (cur_st == L_EXC && own) begin
          nx_st = L_UNC; nx_pres = '0;
        end else if (cur_st == L_WWB && own) begin
          o_v = 1'b1; o_k = M_DATA; o_d = pend_bit;
          nx_st = L_SHR; nx_pres = cur_pres | pend_bit;
        end
      end
      default: begin
        if (cur_st == L_WACK) begin
          nx_cnt = cur_cnt - 1'b1;
          if (cur_cnt == (SW+1)'(1)) begin
            o_v = 1'b1; o_k = M_GRANT; o_d = pend_bit;
            nx_st = L_EXC; nx_pres = pend_bit;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st[i]   <= L_UNC;
        pres[i] <= '0;
        pend[i] <= '0;
        cnt[i]  <= '0;
      end
      msg_valid <= 1'b0;
      msg_kind  <= 3'd0;
      msg_dst   <= '0;
      msg_line  <= '0;
    end else begin
      if (req_valid) begin
        st[req_line]   <= nx_st;
        pres[req_line] <= nx_pres;
        pend[req_line] <= nx_pend;
        cnt[req_line]  <= nx_cnt;
      end
      msg_valid <= req_valid && o_v;
      msg_kind  <= o_k;
      msg_dst   <= o_d;
      msg_line  <= req_line;
    end
  end

  // R1
  msg_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(req_valid));

  // R1
  single_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind != M_INVAL) |-> ($countones(msg_dst) == 1));

  // R4
  inval_skips_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == M_INVAL) |->
      (msg_dst != '0 && (msg_dst & (NCLUST'(1) << $past(req_src))) == '0));

  for (genvar g = 0; g < NLINES; g++) begin : g_line_chk
    // R9
    excl_one_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == L_EXC) |-> ($countones(pres[g]) == 1));
    // R5
    ack_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == L_WACK) |-> (cnt[g] != '0));
  end
endmodule

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;
  localparam int NC = 16;
  localparam int NL = 4;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, WB = 2'd2, AK = 2'd3;
  localparam logic [2:0] DATA = 3'd1, GRANT = 3'd2, NACK = 3'd3, FETCH = 3'd4, INVAL = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [3:0] req_src = '0;
  logic [1:0] req_line = '0;
  logic msg_valid;
  logic [2:0] msg_kind;
  logic [NC-1:0] msg_dst;
  logic [1:0] msg_line;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dir_home_ctrl #(.NCLUST(NC), .NLINES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_src(req_src), .req_line(req_line), .msg_valid(msg_valid),
    .msg_kind(msg_kind), .msg_dst(msg_dst), .msg_line(msg_line));

  function automatic logic [NC-1:0] b(input int c);
    return NC'(1) << c;
  endfunction

  task automatic req(input logic [1:0] k, input int src, input int ln,
                     input bit ev, input logic [2:0] ek, input logic [NC-1:0] ed,
                     input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_src = 4'(src); req_line = 2'(ln);
    @(negedge clk);
    req_valid = 1'b0;
    tests++;
    if (msg_valid !== ev || (ev && (msg_kind !== ek || msg_dst !== ed || msg_line !== 2'(ln)))) begin
      fails++;
      $display("FAIL %s: got v=%0b k=%0d d=%h l=%0d, expected v=%0b k=%0d d=%h l=%0d",
               tag, msg_valid, msg_kind, msg_dst, msg_line, ev, ek, ed, ln);
    end
  endtask

  task automatic t_reset;
    tests++;
    if (msg_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: got msg_valid=%0b, expected 0", msg_valid);
    end
    // R10: an untouched line behaves as uncached
    req(WR, 2, 1, 1, GRANT, b(2), "R10 fresh line grant");
    req(WB, 2, 1, 0, 0, 0, "R7 owner writeback");
  endtask

  task automatic t_share_and_inval;
    req(RD, 3, 0, 1, DATA, b(3), "R2 read uncached");
    req(RD, 5, 0, 1, DATA, b(5), "R2 read shared");
    req(WR, 3, 0, 1, INVAL, b(5), "R4 inval excludes requester");
    req(RD, 7, 0, 1, NACK, b(7), "R6 read busy line");
    req(WR, 8, 0, 1, NACK, b(8), "R6 write busy line");
    req(RD, 7, 1, 1, DATA, b(7), "R6 other line unaffected");
    req(AK, 5, 0, 1, GRANT, b(3), "R5 last ack grants");
  endtask

  task automatic t_fetch;
    req(RD, 3, 0, 1, DATA, b(3), "R2 owner rereads");
    req(RD, 9, 0, 1, FETCH, b(3), "R3 fetch to owner");
    req(WB, 3, 0, 1, DATA, b(9), "R3 data after writeback");
    req(WR, 1, 0, 1, INVAL, b(3) | b(9), "R3 both left sharing");
    req(AK, 3, 0, 0, 0, 0, "R5 first ack silent");
    req(AK, 9, 0, 1, GRANT, b(1), "R5 second ack grants");
  endtask

  task automatic t_writeback;
    req(WR, 4, 2, 1, GRANT, b(4), "R4 immediate grant");
    req(WB, 4, 2, 0, 0, 0, "R7 owner writeback silent");
    req(RD, 6, 2, 1, DATA, b(6), "R7 line uncached after wb");
    req(WR, 6, 2, 1, GRANT, b(6), "R7 old owner bit cleared");
    req(WB, 5, 0, 0, 0, 0, "R7 non-owner writeback silent");
    req(RD, 2, 0, 1, FETCH, b(1), "R7 non-owner wb ignored");
  endtask

  task automatic t_stray_and_wide;
    req(AK, 0, 3, 0, 0, 0, "R8 stray ack silent");
    req(RD, 15, 3, 1, DATA, b(15), "R2 cluster 15 reads");
    req(RD, 14, 3, 1, DATA, b(14), "R2 cluster 14 reads");
    req(RD, 0, 3, 1, DATA, b(0), "R2 cluster 0 reads");
    req(WR, 0, 3, 1, INVAL, b(14) | b(15), "R4 wide inval");
    req(AK, 14, 3, 0, 0, 0, "R5 one ack of two");
    req(AK, 15, 3, 1, GRANT, b(0), "R9 single writer");
    req(AK, 15, 3, 0, 0, 0, "R8 ack after grant ignored");
    req(RD, 14, 3, 1, FETCH, b(0), "R9 owner still exclusive");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_share_and_inval;
    t_fetch;
    t_writeback;
    t_stray_and_wide;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule